// File: doc/BRIEF.md
# Link Detect Phase Sequencer

This block runs the detect phase of a multi-lane serial link training machine. It alternates between a quiet phase and an active phase. The quiet phase waits out a fixed timeout of `QUIET_MS` milliseconds. It may finish early when an enabled lane reports that it has left electrical idle. The active phase asks the transmit side for a receiver detection, holds that request until the transmit side reports completion, and then decides. If every enabled lane found a receiver, the block announces the move to polling. Otherwise it goes back to quiet.

Two protections keep receiver detections from running back to back. First, a programmable minimum dwell masks early exits until that dwell has elapsed in the quiet phase. Second, lanes outside the link are forced to read as idle, so a lane with floating or wrongly tied status cannot cut the quiet phase short. The minimum dwell code comes from bits [2:1] of a control word, which the register file decodes and delivers to the `min_quiet_code` input. All timers count cycles of a reference clock, with `TICKS_PER_MS` cycles per millisecond.

Top module: `lds_detect_seq`

## Requirements
- R1: The reset input `rst_n` is synchronous and active low. While it is low, `rxdet_req` and `to_polling` are 0. Each release of reset starts a fresh quiet phase with its timer cleared, even if reset arrived partway through an earlier quiet phase.
- R2: If no enabled lane leaves idle, `rxdet_req` rises exactly `QUIET_MS*TICKS_PER_MS` clock edges after the edge that entered the quiet phase.
- R3: A lane leaves idle when its bit of `lane_eidle` is 0. If an enabled lane leaves idle and is first sampled as out of idle on edge d after quiet entry, the quiet phase ends on edge max(d, M). M is the minimum dwell from R4, and it is taken as at least 1. The phase never ends later than the timeout of R2.
- R4: `min_quiet_code` sets the minimum dwell M. Code 0 gives 0 ticks, code 1 gives `TICKS_PER_MS/2`, code 2 gives `TICKS_PER_MS`, and code 3 gives `2*TICKS_PER_MS`.
- R5: A lane whose `lane_en` bit is 0 is treated as idle whatever its `lane_eidle` bit says. With no lane enabled, the quiet phase always runs to the full timeout.
- R6: In the active phase, `rxdet_req` stays at 1 until `rxdet_done` is sampled at 1.
- R7: A receiver detection fails when some enabled lane has a 0 in `rxdet_found`, or when no lane is enabled. On a failure the block returns to the quiet phase on that edge. It applies R2 to R4 again, including the minimum dwell, and it does not pulse `to_polling`.
- R8: A receiver detection passes when every enabled lane has a 1 in `rxdet_found`. The cycle after `rxdet_done` is sampled, `to_polling` is 1 and `rxdet_req` is 0. `to_polling` is 1 for exactly one cycle, and the block then holds with `rxdet_req` at 0.
- R9: `restart` takes the block from the held state back to a fresh quiet phase. `restart` and `rxdet_done` are ignored in the quiet phase, and the quiet timing is unchanged.
- R10: `rxdet_found` bits of disabled lanes do not affect the pass/fail decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, `TICKS_PER_MS` cycles per ms |
| rst_n | input | 1 | Synchronous active-low reset |
| min_quiet_code | input | 2 | Minimum quiet dwell code, decoded from control word bits [2:1] |
| lane_en | input | NUM_LANES | Lanes that belong to the link |
| lane_eidle | input | NUM_LANES | Per-lane electrical idle status, 1 = idle |
| restart | input | 1 | Leave the held state and start a new detect phase |
| rxdet_req | output | 1 | Receiver detection request, high during the active phase |
| rxdet_done | input | 1 | Receiver detection finished |
| rxdet_found | input | NUM_LANES | Per-lane receiver present result, valid with `rxdet_done` |
| to_polling | output | 1 | One-cycle pulse: detect succeeded, move to polling |

## Verification
The quiet phase is measured, in edges from entry to the rise of the request, under several patterns:
- No idle exit at all, which pins down the timeout.
- An immediate exit under each of the four dwell codes, which separates the dwell values.
- A late exit, which separates "wait for the dwell" from "wait for the exit".
- An exit on a disabled lane, and an all-disabled mask, which must both give the full timeout.
- Stray `restart` and `rxdet_done` pulses during the quiet phase, which must leave the timing unchanged.

Detection results are checked in three forms: all enabled lanes found, one enabled lane missing, and found bits set only on disabled lanes. Together these separate masking from plain AND-reduction. Each failure chains straight into the next measured quiet phase, which shows that the minimum dwell applies again after a failed detection. Seeded random trials mix codes, masks, exit lanes, exit times and results against the same bench functions.

// File: rtl/lds_pkg.sv
package lds_pkg;

    typedef enum logic [1:0] {
        DET_QUIET  = 2'd0,
        DET_ACTIVE = 2'd1,
        DET_DONE   = 2'd2
    } det_state_e;

    typedef struct packed {
        det_state_e st;
        logic       pulse;
    } seq_regs_s;

    // Minimum quiet dwell, in reference ticks, for a 2-bit code.
    function automatic int unsigned min_dwell_ticks(input logic [1:0] code,
                                                    input int unsigned tpm);
        case (code)
            2'd0:    return 0;
            2'd1:    return tpm / 2;
            2'd2:    return tpm;
            default: return 2 * tpm;
        endcase
    endfunction

endpackage

// File: rtl/lds_lane_filter.sv
module lds_lane_filter #(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] lane_en,
    input  logic [NUM_LANES-1:0] lane_eidle,
    input  logic [NUM_LANES-1:0] rx_found,
    output logic                 exit_seen,
    output logic                 all_found
);

    logic [NUM_LANES-1:0] eff_idle;
    logic [NUM_LANES-1:0] lane_ok;

    // Lanes outside the link read as idle and as "found"
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        assign eff_idle[i] = lane_eidle[i] | ~lane_en[i];
        assign lane_ok[i]  = rx_found[i]   | ~lane_en[i];
    end

    assign exit_seen = ~(&eff_idle);
    assign all_found = (&lane_ok) & (|lane_en);

    // Disabled lanes can never report an idle exit
    assert_mask_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_eidle == '0 && lane_en == '0) |-> !exit_seen);

    // Found bits on disabled lanes alone never pass the detection
    assert_found_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_found == ~lane_en && lane_en != '1) |-> !all_found);

endmodule

// File: rtl/lds_dwell_timer.sv
module lds_dwell_timer #(
    parameter int TICKS_PER_MS = 1000,
    parameter int LIMIT        = 12000,
    localparam int CW          = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [1:0]    min_code,
    output logic [CW-1:0] elapsed,
    output logic          min_met,
    output logic          timeout
);

    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] min_ticks;

    always_comb begin
        cnt_d = '0;
        if (run) begin
            cnt_d = (cnt_q < LAST) ? cnt_q + 1'b1 : cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign min_ticks = CW'(lds_pkg::min_dwell_ticks(min_code, TICKS_PER_MS));
    assign elapsed   = cnt_q + 1'b1;
    assign min_met   = (elapsed >= min_ticks);
    assign timeout   = (elapsed >= CW'(LIMIT));

    // Counter never runs past the quiet limit
    assert_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // Leaving the quiet phase clears the timer for the next entry
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/lds_detect_seq.sv
module lds_detect_seq #(
    parameter int NUM_LANES    = 4,
    parameter int TICKS_PER_MS = 1000,
    parameter int QUIET_MS     = 12,
    localparam int QUIET_TICKS = QUIET_MS * TICKS_PER_MS,
    localparam int CW          = $clog2(QUIET_TICKS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           min_quiet_code,
    input  logic [NUM_LANES-1:0] lane_en,
    input  logic [NUM_LANES-1:0] lane_eidle,
    input  logic                 restart,
    output logic                 rxdet_req,
    input  logic                 rxdet_done,
    input  logic [NUM_LANES-1:0] rxdet_found,
    output logic                 to_polling
);
    import lds_pkg::*;

    seq_regs_s r_d, r_q;

    logic          exit_seen;
    logic          all_found;
    logic          in_quiet;
    logic [CW-1:0] elapsed;
    logic          min_met;
    logic          timeout;

    lds_lane_filter #(
        .NUM_LANES (NUM_LANES)
    ) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_en    (lane_en),
        .lane_eidle (lane_eidle),
        .rx_found   (rxdet_found),
        .exit_seen  (exit_seen),
        .all_found  (all_found)
    );

    assign in_quiet = (r_q.st == DET_QUIET);

    lds_dwell_timer #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .LIMIT        (QUIET_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (in_quiet),
        .min_code (min_quiet_code),
        .elapsed  (elapsed),
        .min_met  (min_met),
        .timeout  (timeout)
    );

    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        case (r_q.st)
            DET_QUIET: begin
                if (timeout || (exit_seen && min_met)) begin
                    r_d.st = DET_ACTIVE;
                end
            end
            DET_ACTIVE: begin
                if (rxdet_done) begin
                    if (all_found) begin
                        r_d.st    = DET_DONE;
                        r_d.pulse = 1'b1;
                    end else begin
                        r_d.st = DET_QUIET;
                    end
                end
            end
            DET_DONE: begin
                if (restart) begin
                    r_d.st = DET_QUIET;
                end
            end
            default: r_d.st = DET_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= DET_QUIET;
            r_q.pulse <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rxdet_req  = (r_q.st == DET_ACTIVE);
    assign to_polling = r_q.pulse;

    // Leaving quiet only after the timer reports dwell or timeout
    assert_min_dwell_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rxdet_req && $past(in_quiet)) |-> $past(min_met || timeout));

    // Request held until completion is seen
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rxdet_req && !rxdet_done) |=> rxdet_req);

    // Polling pulse lasts a single cycle
    assert_pulse_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        to_polling |=> !to_polling);

    // Polling pulse only follows a completed detection
    assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        to_polling |-> ($past(rxdet_req) && $past(rxdet_done)));

    // Request and polling pulse never overlap
    assert_req_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(to_polling && rxdet_req));

endmodule

// File: tb/lds_detect_seq_tb.sv
`timescale 1ns/1ps
module lds_detect_seq_tb;

    localparam int NL  = 4;
    localparam int TPM = 8;
    localparam int QMS = 12;
    localparam int QT  = QMS * TPM;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    min_quiet_code;
    logic [NL-1:0] lane_en;
    logic [NL-1:0] lane_eidle;
    logic          restart;
    logic          rxdet_req;
    logic          rxdet_done;
    logic [NL-1:0] rxdet_found;
    logic          to_polling;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lds_detect_seq #(
        .NUM_LANES    (NL),
        .TICKS_PER_MS (TPM),
        .QUIET_MS     (QMS)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .min_quiet_code (min_quiet_code),
        .lane_en        (lane_en),
        .lane_eidle     (lane_eidle),
        .restart        (restart),
        .rxdet_req      (rxdet_req),
        .rxdet_done     (rxdet_done),
        .rxdet_found    (rxdet_found),
        .to_polling     (to_polling)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_min(input logic [1:0] code);
        case (code)
            2'd0:    return 0;
            2'd1:    return TPM / 2;
            2'd2:    return TPM;
            default: return 2 * TPM;
        endcase
    endfunction

    // Edges from quiet entry to request; exit first sampled on edge d+1
    function automatic int exp_quiet(input logic [1:0] code, input int d, input bit exit_on);
        int e;
        if (!exit_on) return QT;
        e = (exp_min(code) > d + 1) ? exp_min(code) : d + 1;
        return (e < QT) ? e : QT;
    endfunction

    function automatic bit exp_pass(input logic [NL-1:0] en, input logic [NL-1:0] found);
        return (en != '0) && ((found & en) == en);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Called at a negedge, zero edges after quiet entry
    task automatic trial(input logic [1:0] code, input logic [NL-1:0] en, input int lane,
                         input int d, input logic [NL-1:0] found, input bit noise,
                         input string tag);
        int k;
        int got;
        int exp;
        bit pass;
        min_quiet_code = code;
        lane_en        = en;
        lane_eidle     = '1;
        if (d == 0) lane_eidle[lane] = 1'b0;
        k   = 0;
        got = -1;
        while (got < 0 && k < QT + 4) begin
            tick();
            k++;
            if (rxdet_req) begin
                got = k;
            end else begin
                if (k == d) lane_eidle[lane] = 1'b0;
                if (noise && k == 3) begin
                    rxdet_done  = 1'b1;
                    restart     = 1'b1;
                    rxdet_found = '1;
                end
                if (noise && k == 4) begin
                    rxdet_done = 1'b0;
                    restart    = 1'b0;
                end
            end
        end
        exp = exp_quiet(code, d, en[lane]);
        check(got == exp, tag, got, exp);
        lane_eidle  = '1;
        rxdet_found = found;
        tick();
        check(rxdet_req == 1'b1, "R6 request held", int'(rxdet_req), 1);
        tick();
        check(rxdet_req == 1'b1 && to_polling == 1'b0, "R6 request held", int'(rxdet_req), 1);
        rxdet_done = 1'b1;
        tick();
        rxdet_done = 1'b0;
        pass = exp_pass(en, found);
        if (pass) begin
            check(to_polling == 1'b1 && rxdet_req == 1'b0, "R8 polling pulse", int'(to_polling), 1);
            tick();
            check(to_polling == 1'b0, "R8 pulse one cycle", int'(to_polling), 0);
            tick();
            tick();
            check(rxdet_req == 1'b0 && to_polling == 1'b0, "R8 holds done", int'(rxdet_req), 0);
            restart = 1'b1;
            tick();
            restart = 1'b0;
            check(rxdet_req == 1'b0, "R9 restart to quiet", int'(rxdet_req), 0);
        end else begin
            check(to_polling == 1'b0 && rxdet_req == 1'b0, "R7 fail back to quiet",
                  int'(to_polling | rxdet_req), 0);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_errs++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        rst_n          = 1'b0;
        min_quiet_code = 2'd3;
        lane_en        = '1;
        lane_eidle     = '0;
        restart        = 1'b0;
        rxdet_done     = 1'b1;
        rxdet_found    = '1;
        repeat (4) tick();
        check(rxdet_req == 1'b0 && to_polling == 1'b0, "R1 reset outputs",
              int'(rxdet_req | to_polling), 0);
        rxdet_done = 1'b0;
        lane_eidle = '1;
        rst_n      = 1'b1;
        // Partway through quiet, reset again: timer must start over
        repeat (50) tick();
        rst_n = 1'b0;
        repeat (2) tick();
        check(rxdet_req == 1'b0, "R1 reset in quiet", int'(rxdet_req), 0);
        rst_n = 1'b1;
        trial(2'd3, 4'hF, 0, 500, 4'hF, 1'b0, "R1 R2 timeout after reset");

        trial(2'd0, 4'hF, 0, 0, 4'h0, 1'b0, "R3 immediate exit code0");
        trial(2'd3, 4'hF, 2, 0, 4'hF, 1'b0, "R4 R7 code3 dwell after fail");
        trial(2'd1, 4'hF, 1, 0, 4'h7, 1'b0, "R4 code1 dwell");
        trial(2'd2, 4'hF, 3, 0, 4'hB, 1'b0, "R4 R7 code2 dwell after fail");
        trial(2'd0, 4'b0011, 3, 0, 4'b1101, 1'b0, "R5 exit on disabled lane");
        trial(2'd0, 4'b0011, 1, 0, 4'b1100, 1'b0, "R10 found only on disabled lanes");
        trial(2'd0, 4'b0011, 1, 0, 4'b1111, 1'b0, "R10 disabled found bits ignored");
        trial(2'd3, 4'hF, 2, 30, 4'hF, 1'b0, "R3 late exit");
        trial(2'd0, 4'hF, 0, 500, 4'hF, 1'b0, "R9 stray restart and done in quiet");
        trial(2'd0, 4'hF, 0, 500, 4'h3, 1'b1, "R9 stray restart and done in quiet");
        trial(2'd0, 4'h0, 0, 0, 4'hF, 1'b0, "R5 R7 no lane enabled");

        for (int t = 0; t < 40; t++) begin
            logic [1:0]    c;
            logic [NL-1:0] en;
            logic [NL-1:0] fd;
            int            ln;
            int            dd;
            c  = 2'($urandom_range(0, 3));
            en = NL'($urandom_range(0, (1 << NL) - 1));
            ln = $urandom_range(0, NL - 1);
            dd = $urandom_range(0, QT + 10);
            fd = ($urandom_range(0, 1) == 1) ? (en | NL'($urandom_range(0, (1 << NL) - 1)))
                                             : NL'($urandom_range(0, (1 << NL) - 1));
            trial(c, en, ln, dd, fd, 1'b0, "R3/R4/R5 random quiet");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule